// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block keeps the status byte of a serial NOR flash slave and decides whether each modifying instruction may run. The command decoder hands it one strobe per decoded instruction, with the data byte and the target address. The block then answers with a one-cycle accept or reject pulse. When it accepts a program or erase, it also sends a start pulse and an operation code to the array engine. It holds the write-enable latch, the busy flag, three block-protect bits and a status-write-disable bit. That last bit works together with the active-low write-protect pin to freeze the protection settings.

The block-protect value selects a protected region at the top of the address space. The region grows from 1/64 of the array at value 1 and doubles with each step, up to the whole array at value 7. Bulk erase is allowed only when no region is protected and the lock-register flags are not all set. Two resets are provided. The soft reset clears only the volatile state. The power-on reset also clears the protection bits, which stand in for non-volatile cells.

Top module: `flash_status_guard`

## Requirements
- R1: `status_byte` reads bit 7 = SRWD (status write disable), bits 6:5 = 0, bits 4:2 = BP (block protect, BP2 at bit 4), bit 1 = WEL (write enable latch), bit 0 = WIP (write in progress), and it always shows the current state, including while WIP is 1.
- R2: A write-enable strobe sets WEL and a write-disable strobe clears it. Neither strobe produces a verdict pulse.
- R3: When WEL is 0, every modifying instruction (status write, page program, sector erase, subsector erase, bulk erase) is rejected and changes no status bit.
- R4: An accepted status write loads SRWD from data bit 7 and BP from data bits 4:2. WIP then reads 1 for exactly SRW_CYCLES cycles, and WEL clears when WIP drops.
- R5: When SRWD is 1 and `wp_n` is low, a status write is rejected and SRWD and BP stay unchanged. With `wp_n` high, it follows R4.
- R6: When BP is not 0, a page program, sector erase or subsector erase to an address at or above 2^ADDR_W − 2^ADDR_W·2^(BP−1)/64 is rejected. An address below that bound is accepted when WEL is 1.
- R7: Bulk erase is accepted only when WEL is 1, BP is 0 and `lock_all_set` is 0.
- R8: An accepted program or erase raises `eng_start` together with `op_accept`, with `eng_op` = 0 page program, 1 sector erase, 2 subsector erase, 3 bulk erase. WIP reads 1 from that cycle until the cycle after `engine_busy` falls, and at that point WEL clears.
- R9: A verdict pulse lasts one cycle and comes the cycle after the strobe. Accept and reject are never high together, and a reject clears WEL.
- R10: While WIP is 1, every strobe other than read-status is ignored: no verdict is given and WEL is unchanged.
- R11: A soft reset clears WEL and WIP and keeps SRWD and BP. A power-on reset clears all of them.
- R12: A read-status strobe gives no verdict and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears every bit |
| rst_n | input | 1 | Soft reset, active low, clears only the volatile state |
| cmd_wren | input | 1 | Write-enable instruction strobe |
| cmd_wrdi | input | 1 | Write-disable instruction strobe |
| cmd_wrsr | input | 1 | Status-write instruction strobe |
| cmd_pp | input | 1 | Page-program instruction strobe |
| cmd_se | input | 1 | Sector-erase instruction strobe |
| cmd_sse | input | 1 | Subsector-erase instruction strobe |
| cmd_be | input | 1 | Bulk-erase instruction strobe |
| cmd_rdsr | input | 1 | Read-status instruction strobe |
| cmd_data | input | 8 | Data byte for a status write |
| cmd_addr | input | ADDR_W | Target address for program and erase |
| wp_n | input | 1 | Write-protect pin, active low |
| engine_busy | input | 1 | Array engine is running a cycle |
| lock_all_set | input | 1 | All lock-register protection flags are set |
| status_byte | output | 8 | Current status byte |
| op_accept | output | 1 | Modifying instruction accepted |
| op_reject | output | 1 | Modifying instruction rejected |
| eng_start | output | 1 | Start pulse to the array engine |
| eng_op | output | 2 | Operation code for the array engine |

## Verification
The bench builds the block with ADDR_W = 12 and SRW_CYCLES = 5. With these values every protection bound is a small integer, so directed addresses can sit exactly on each bound and one below it, and random addresses land inside narrow regions often. The short status-write cycle keeps each step brief. This leaves room for an exhaustive sweep over BP, SRWD, pin level, WEL and instruction, with a stray strobe injected during every array cycle.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W     = 20,
  parameter int SRW_CYCLES = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_sse,
  input  logic              cmd_be,
  input  logic              cmd_rdsr,
  input  logic [7:0]        cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  input  logic              engine_busy,
  input  logic              lock_all_set,
  output logic [7:0]        status_byte,
  output logic              op_accept,
  output logic              op_reject,
  output logic              eng_start,
  output logic [1:0]        eng_op
);
  localparam int CW  = $clog2(SRW_CYCLES + 1);
  localparam int SH0 = ADDR_W - 7;

  logic          srwd, wel, arr_run, busy_q;
  logic [2:0]    bp;
  logic [CW-1:0] sr_cnt;
  logic          wip, modify, hw_lock, area_hit, deny, accept_now, reject_now;
  logic [ADDR_W-1:0] prot_mask;
  logic          soft_clr;
  logic          unused_bits;

  assign unused_bits = &{1'b0, cmd_data[6:5], cmd_data[1:0], cmd_rdsr};
  assign soft_clr    = !rst_n || !por_n;

  assign wip       = arr_run || (sr_cnt != '0);
  assign modify    = cmd_wrsr | cmd_pp | cmd_se | cmd_sse | cmd_be;
  assign hw_lock   = srwd & ~wp_n;
  assign prot_mask = {ADDR_W{1'b1}} << (SH0 + int'(bp));
  assign area_hit  = (bp != 3'd0) && ((cmd_addr & prot_mask) == prot_mask);

  always_comb begin
    deny = ~wel;
    if (cmd_wrsr)                   deny = deny | hw_lock;
    if (cmd_pp | cmd_se | cmd_sse)  deny = deny | area_hit;
    if (cmd_be)                     deny = deny | (bp != 3'd0) | lock_all_set;
  end

  assign accept_now = modify & ~wip & ~deny;
  assign reject_now = modify & ~wip & deny;

  assign status_byte = {srwd, 2'b00, bp, wel, wip};

  always_ff @(posedge clk) begin
    if (soft_clr) begin
      wel       <= 1'b0;
      arr_run   <= 1'b0;
      sr_cnt    <= '0;
      busy_q    <= 1'b0;
      op_accept <= 1'b0;
      op_reject <= 1'b0;
      eng_start <= 1'b0;
      eng_op    <= 2'd0;
    end else begin
      busy_q    <= engine_busy;
      op_accept <= accept_now;
      op_reject <= reject_now;
      eng_start <= accept_now & ~cmd_wrsr;
      eng_op    <= {cmd_sse | cmd_be, cmd_se | cmd_be};
      if (!wip) begin
        if (cmd_wren)                wel <= 1'b1;
        if (cmd_wrdi || reject_now)  wel <= 1'b0;
        if (accept_now && cmd_wrsr)  sr_cnt <= CW'(SRW_CYCLES);
        if (accept_now && !cmd_wrsr) arr_run <= 1'b1;
      end else begin
        if (sr_cnt != '0) begin
          sr_cnt <= sr_cnt - 1'b1;
          if (sr_cnt == CW'(1)) wel <= 1'b0;
        end
        if (arr_run && busy_q && !engine_busy) begin
          arr_run <= 1'b0;
          wel     <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      srwd <= 1'b0;
      bp   <= 3'd0;
    end else if (rst_n && accept_now && cmd_wrsr) begin
      srwd <= cmd_data[7];
      bp   <= cmd_data[4:2];
    end
  end

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (soft_clr)
    !(op_accept && op_reject));

  // R10
  wip_ignore_chk: assert property (@(posedge clk) disable iff (soft_clr)
    wip && (modify || cmd_wren || cmd_wrdi) |=> !op_accept && !op_reject);

  // R3
  no_wel_chk: assert property (@(posedge clk) disable iff (soft_clr)
    !wip && !wel && modify |=> op_reject);

  // R5
  hw_lock_chk: assert property (@(posedge clk) disable iff (soft_clr)
    !wip && srwd && !wp_n && cmd_wrsr |=> op_reject && $stable(status_byte[7:2]));

  // R7
  be_gate_chk: assert property (@(posedge clk) disable iff (soft_clr)
    !wip && cmd_be && (bp != 3'd0 || lock_all_set) |=> op_reject);

  // R8
  start_chk: assert property (@(posedge clk) disable iff (soft_clr)
    eng_start |-> op_accept && status_byte[0]);

  // R12
  rdsr_quiet_chk: assert property (@(posedge clk) disable iff (soft_clr)
    cmd_rdsr && !modify |=> !op_accept && !op_reject);
endmodule

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int SRW = 5;

  logic clk = 1'b0;
  logic por_n, rst_n;
  logic cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_sse, cmd_be, cmd_rdsr;
  logic [7:0] cmd_data;
  logic [AW-1:0] cmd_addr;
  logic wp_n, engine_busy, lock_all_set;
  logic [7:0] status_byte;
  logic op_accept, op_reject, eng_start;
  logic [1:0] eng_op;

  int n_tests = 0, n_fail = 0;
  bit m_wel, m_srwd;
  logic [2:0] m_bp;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_guard #(.ADDR_W(AW), .SRW_CYCLES(SRW)) dut_i (
    .clk, .por_n, .rst_n, .cmd_wren, .cmd_wrdi, .cmd_wrsr, .cmd_pp, .cmd_se,
    .cmd_sse, .cmd_be, .cmd_rdsr, .cmd_data, .cmd_addr, .wp_n, .engine_busy,
    .lock_all_set, .status_byte, .op_accept, .op_reject, .eng_start, .eng_op);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bound(input int b);
    return (1 << AW) - ((1 << AW) >> (7 - b));
  endfunction

  function automatic bit prot(input int b, input int a);
    if (b == 0) return 1'b0;
    return a >= bound(b);
  endfunction

  task automatic set_strobes(input int op, input bit on);
    cmd_wren = on && op == 0; cmd_wrdi = on && op == 1; cmd_wrsr = on && op == 2;
    cmd_pp   = on && op == 3; cmd_se   = on && op == 4; cmd_sse  = on && op == 5;
    cmd_be   = on && op == 6; cmd_rdsr = on && op == 7;
  endtask

  task automatic chk_status(input string req);
    logic [7:0] exp;
    exp = {m_srwd, 2'b00, m_bp, m_wel, 1'b0};
    chk(status_byte == exp, req, 32'(status_byte), 32'(exp));
  endtask

  // op: 0 wren,1 wrdi,2 wrsr,3 pp,4 se,5 sse,6 be,7 rdsr
  task automatic issue(input int op, input logic [7:0] d, input int a);
    bit modify, deny;
    int cnt;
    modify = op >= 2 && op <= 6;
    deny = !m_wel;
    if (op == 2) deny = deny || (m_srwd && !wp_n);
    if (op >= 3 && op <= 5) deny = deny || prot(int'(m_bp), a);
    if (op == 6) deny = deny || m_bp != 0 || lock_all_set;
    @(negedge clk);
    cmd_data = d; cmd_addr = AW'(a);
    set_strobes(op, 1'b1);
    @(negedge clk);
    set_strobes(0, 1'b0);
    if (!modify) begin
      chk(!op_accept && !op_reject, op == 7 ? "R12 rdsr verdict" : "R2 wren/wrdi verdict",
          {op_accept, op_reject}, 0);
      if (op == 0) m_wel = 1'b1;
      if (op == 1) m_wel = 1'b0;
      chk_status(op == 7 ? "R12 status after rdsr" : "R2 status");
      return;
    end
    chk(op_accept == !deny && op_reject == deny, "R3/R5/R6/R7/R9 verdict",
        {op_accept, op_reject}, {!deny, deny});
    if (deny) begin
      m_wel = 1'b0;
      chk_status("R9 status after reject");
      return;
    end
    if (op == 2) begin
      m_srwd = d[7]; m_bp = d[4:2];
      cnt = 0;
      while (status_byte[0] && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == SRW, "R4 WIP length", cnt, SRW);
      m_wel = 1'b0;
      chk_status("R4 status after write");
    end else begin
      chk(eng_start && eng_op == 2'(op - 3), "R8 engine start", {eng_start, eng_op}, {1'b1, 2'(op - 3)});
      engine_busy = 1'b1;
      set_strobes($urandom % 5 + 2 == 3 ? 0 : int'($urandom % 2), 1'b1);
      @(negedge clk);
      set_strobes(0, 1'b0);
      chk(!op_accept && !op_reject, "R10 strobe ignored while busy", {op_accept, op_reject}, 0);
      chk(status_byte[1:0] == 2'b11, "R10 WEL/WIP held while busy", status_byte[1:0], 3);
      repeat (2) @(negedge clk);
      engine_busy = 1'b0;
      @(negedge clk);
      m_wel = 1'b0;
      chk_status("R8 status after array cycle");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed_1234);
    por_n = 0; rst_n = 0; set_strobes(0, 1'b0);
    cmd_data = 0; cmd_addr = 0; wp_n = 1; engine_busy = 0; lock_all_set = 0;
    m_wel = 0; m_srwd = 0; m_bp = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    chk(status_byte == 8'h00, "R11 power-on status", status_byte, 0);

    // R1 layout with distinct fields
    issue(0, 0, 0);
    chk(status_byte == 8'h02, "R1 WEL at bit 1", status_byte, 2);
    issue(2, 8'b1001_0100, 0);
    chk(status_byte == 8'h94, "R1 SRWD bit 7, BP at 4:2", status_byte, 8'h94);

    // R5 hardware lock, then release by pin
    wp_n = 0;
    issue(0, 0, 0);
    issue(2, 8'h00, 0);
    wp_n = 1;
    issue(0, 0, 0);
    issue(2, 8'h00, 0);

    // R3 no WEL
    issue(3, 0, 0);
    issue(6, 0, 0);

    // R11 soft reset keeps NV bits
    issue(0, 0, 0);
    issue(2, 8'h8c, 0);
    issue(0, 0, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_wel = 0;
    @(negedge clk);
    chk_status("R11 soft reset keeps SRWD/BP");
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    m_srwd = 0; m_bp = 0;
    @(negedge clk);
    chk_status("R11 power-on clears all");

    // exhaustive sweep with random addresses, data and lock flags
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int e = 0; e < 2; e++)
            for (int op = 2; op < 7; op++) begin
              int a, pick;
              wp_n = 1;
              issue(0, 0, 0);
              issue(2, {1'(s), 2'b00, 3'(b), 2'b00}, 0);
              if (e == 1) issue(0, 0, 0);
              wp_n = 1'(w);
              lock_all_set = ($urandom % 3) == 0;
              pick = $urandom % 3;
              if (pick == 0)      a = bound(b);
              else if (pick == 1) a = (bound(b) - 1) & ((1 << AW) - 1);
              else                a = $urandom % (1 << AW);
              issue(op, 8'($urandom), a);
            end

    // random mix
    for (int i = 0; i < 400; i++) begin
      wp_n = 1'($urandom);
      lock_all_set = ($urandom % 4) == 0;
      issue($urandom % 8, 8'($urandom), $urandom % (1 << AW));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule